// File: doc/BRIEF.md
# Interrupt Unit with Countdown Timer

This unit collects interrupt requests for a small in-order processor core and decides when the core must leave its program for a handler. Three sources feed a pending register. The first is an external request line. The second is a built-in 32-bit countdown timer. The third is a strobe the decoder raises when it meets an instruction it cannot execute. Software enables sources through a 5-bit mask. When the core signals an instruction boundary and no handler is running, the unit starts a short entry sequence. That sequence saves the interrupted PC and the winning source number into shadow registers, marks a handler as active and redirects fetch to a fixed handler address.

The core reaches the four 32-bit shadow registers through a plain write port and a combinational read port, so handler code can move values to and from them. A return command ends the handler and sends fetch back to the saved PC. An illegal instruction that cannot be trapped stops the core for good through a sticky halt output.

Top module: `intc_timer_unit`

## Requirements
- R1: After reset the mask is 0, no handler is active, `halt`, `redirect` and `req` are 0, and the timer is stopped, so no request appears without stimulus.
- R2: Loading a nonzero value N makes the timer count down once per cycle. It raises pending bit 1 on the edge where it passes from 1 to 0, which is N cycles after the load edge. Loading 0 stops it, and it then never raises bit 1.
- R3: A single high cycle on `ext_req` sets pending bit 0. The bit stays set after the line drops, until an entry takes it. Mask bit 0 gates only the request, not the capture.
- R4: `req` is 1 exactly when (pending AND mask) is nonzero and no handler is active. An entry starts only at an edge where `boundary` and `req` are both 1.
- R5: On the edge after acceptance, shadow register 0 receives the `cur_pc` presented at acceptance, `in_handler` rises, and `redirect` pulses with `redirect_pc` = HANDLER_ADDR (default 16). One edge later, shadow register 1 receives the source number, zero-extended. Shadow registers 2 and 3 are not touched.
- R6: The lowest-numbered enabled pending bit wins (0 = external, 1 = timer, 2 = illegal instruction). Only that bit is cleared, in the same step that records the number. If none of bits 0 to 3 qualifies at that step, the number 4 is recorded.
- R7: While a handler is active no new entry starts, whatever the pending and mask state.
- R8: `ret_cmd` while a handler is active and no entry is in progress clears `in_handler` and pulses `redirect` with `redirect_pc` equal to shadow register 0.
- R9: `ill_strobe` with mask bit 2 set and no handler active sets pending bit 2 and leaves `halt` low. In any other case it sets `halt`, which then stays 1 until reset.
- R10: `shd_we` writes `shd_wdata` to the shadow register selected by `shd_waddr` at the next edge. `shd_rdata` shows the register selected by `shd_raddr` in the same cycle.
- R11: `redirect` is a one-cycle pulse. It is 0 in the cycle after an entry redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External interrupt request line |
| ill_strobe | input | 1 | Decoder met an unsupported instruction |
| boundary | input | 1 | Core is at an instruction boundary |
| cur_pc | input | 32 | PC of the next instruction at the boundary |
| mask_we | input | 1 | Write the enable mask |
| mask_wdata | input | 5 | New mask value |
| tmr_load | input | 1 | Load the countdown timer |
| tmr_wdata | input | 32 | Timer load value (0 stops it) |
| ret_cmd | input | 1 | Return from handler |
| shd_we | input | 1 | Shadow register write enable |
| shd_waddr | input | 2 | Shadow register write index |
| shd_wdata | input | 32 | Shadow register write data |
| shd_raddr | input | 2 | Shadow register read index |
| shd_rdata | output | 32 | Shadow register read data |
| req | output | 1 | An enabled interrupt is pending and may be taken |
| in_handler | output | 1 | A handler is active |
| redirect | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | 32 | Target of the redirect |
| halt | output | 1 | Sticky stop after an untrappable illegal instruction |

## Verification
The hardest case to reach is recording number 4. The pending and mask state must stop qualifying between acceptance and the step that records the number. The stimulus gets there by writing the mask to zero in the cycle right after acceptance. The bench also has to produce two pending sources at once, so it loads the timer with 1 in the same cycle that it pulses the external line.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int NSRC = 5;
   localparam int IDXW = 3;
   localparam int SRC_EXT = 0;
   localparam int SRC_TMR = 1;
   localparam int SRC_ILL = 2;

   typedef enum logic [1:0] {
      ENT_IDLE  = 2'd0,
      ENT_SAVE  = 2'd1,
      ENT_CAUSE = 2'd2
   } ent_state_t;

   // lowest set bit among 0..NSRC-2 wins; otherwise the top index
   function automatic logic [IDXW-1:0] pick_src(input logic [NSRC-1:0] v);
      logic [IDXW-1:0] r;
      r = IDXW'(NSRC - 1);
      for (int i = NSRC - 2; i >= 0; i--)
         if (v[i]) r = IDXW'(i);
      return r;
   endfunction
endpackage

// File: rtl/intc_countdown.sv
module intc_countdown #(
   parameter int W      = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);
   if (W < 2) begin : g_chk_w
      $error("intc_countdown: W must be at least 2");
   end

   if (ENABLE) begin : g_tmr
      logic [W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (load)           cnt <= load_val;
         else if (cnt != '0)      cnt <= cnt - 1'b1;
      end

      // pending is set on the same edge the count leaves 1
      assign expire = (cnt == W'(1)) && !load;

      p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
      p_timer_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == '0 && !load) |=> (cnt == '0));
   end else begin : g_no_tmr
      logic unused_tmr;
      assign unused_tmr = ^{load, load_val, clk, rst_n};
      assign expire = 1'b0;
   end
endmodule

// File: rtl/intc_pending.sv
module intc_pending
   import intc_pkg::*;
#(
   parameter bit EN_EXT = 1'b1,
   parameter bit EN_TMR = 1'b1,
   parameter bit EN_ILL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext_req,
   input  logic            tmr_expire,
   input  logic            ill_set,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);
   logic [NSRC-1:0] set_v;

   always_comb begin
      set_v          = '0;
      set_v[SRC_EXT] = ext_req    && EN_EXT;
      set_v[SRC_TMR] = tmr_expire && EN_TMR;
      set_v[SRC_ILL] = ill_set    && EN_ILL;
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      pend[g] <= 1'b0;
         else if (clr[g]) pend[g] <= 1'b0;
         else if (set_v[g]) pend[g] <= 1'b1;
      end
   end

   p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[SRC_EXT] && !clr[SRC_EXT]) |=> pend[SRC_EXT]);
   p_rsvd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[NSRC-1] && !pend[NSRC-2]);
endmodule

// File: rtl/intc_entry.sv
module intc_entry
   import intc_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter int              NSHD         = 4,
   parameter logic [XLEN-1:0] HANDLER_ADDR = 16,
   parameter logic [XLEN-1:0] RESET_PC     = 0,
   localparam int             SAW          = $clog2(NSHD)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boundary,
   input  logic            hit,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [IDXW-1:0] cause,
   input  logic            ret_cmd,
   input  logic            shd_we,
   input  logic [SAW-1:0]  shd_waddr,
   input  logic [XLEN-1:0] shd_wdata,
   input  logic [SAW-1:0]  shd_raddr,
   output logic [XLEN-1:0] shd_rdata,
   output logic            active,
   output logic            take,
   output logic            redirect,
   output logic [XLEN-1:0] redirect_pc
);
   if (NSHD < 2) begin : g_chk_nshd
      $error("intc_entry: at least two shadow registers needed");
   end

   ent_state_t      st;
   logic [XLEN-1:0] pc_hold;
   logic [XLEN-1:0] shd [NSHD];
   logic            accept;
   logic            do_ret;

   assign accept = boundary && hit && !active && (st == ENT_IDLE);
   assign do_ret = ret_cmd && active && (st == ENT_IDLE);
   assign take   = (st == ENT_CAUSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ENT_IDLE;
         pc_hold <= '0;
      end else begin
         unique case (st)
            ENT_IDLE:  if (accept) begin
                          st      <= ENT_SAVE;
                          pc_hold <= cur_pc;
                       end
            ENT_SAVE:  st <= ENT_CAUSE;
            default:   st <= ENT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active      <= 1'b0;
         redirect    <= 1'b0;
         redirect_pc <= RESET_PC;
      end else begin
         redirect <= 1'b0;
         if (st == ENT_SAVE) begin
            active      <= 1'b1;
            redirect    <= 1'b1;
            redirect_pc <= HANDLER_ADDR;
         end else if (do_ret) begin
            active      <= 1'b0;
            redirect    <= 1'b1;
            redirect_pc <= shd[0];
         end
      end
   end

   for (genvar g = 0; g < NSHD; g++) begin : g_shd
      logic ent_wr;
      logic [XLEN-1:0] ent_val;
      if (g == 0) begin : g_ret_addr
         assign ent_wr  = (st == ENT_SAVE);
         assign ent_val = pc_hold;
      end else if (g == 1) begin : g_cause
         assign ent_wr  = take;
         assign ent_val = XLEN'(cause);
      end else begin : g_free
         assign ent_wr  = 1'b0;
         assign ent_val = '0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)                                  shd[g] <= '0;
         else if (ent_wr)                             shd[g] <= ent_val;
         else if (shd_we && shd_waddr == SAW'(g))     shd[g] <= shd_wdata;
      end
   end

   assign shd_rdata = shd[shd_raddr];

   p_entry_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENT_SAVE) |=> (redirect && redirect_pc == HANDLER_ADDR && active));
   p_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENT_IDLE && active) |=> (st != ENT_SAVE));
   p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      do_ret |=> (!active && redirect));
   p_redirect_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENT_SAVE) |=> ##1 !redirect);
endmodule

// File: rtl/intc_timer_unit.sv
module intc_timer_unit
   import intc_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter logic [XLEN-1:0] HANDLER_ADDR = 16,
   parameter logic [XLEN-1:0] RESET_PC     = 0,
   parameter bit              EN_EXT       = 1'b1,
   parameter bit              EN_TMR       = 1'b1,
   parameter bit              EN_ILL       = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext_req,
   input  logic            ill_strobe,
   input  logic            boundary,
   input  logic [XLEN-1:0] cur_pc,
   input  logic            mask_we,
   input  logic [NSRC-1:0] mask_wdata,
   input  logic            tmr_load,
   input  logic [XLEN-1:0] tmr_wdata,
   input  logic            ret_cmd,
   input  logic            shd_we,
   input  logic [1:0]      shd_waddr,
   input  logic [XLEN-1:0] shd_wdata,
   input  logic [1:0]      shd_raddr,
   output logic [XLEN-1:0] shd_rdata,
   output logic            req,
   output logic            in_handler,
   output logic            redirect,
   output logic [XLEN-1:0] redirect_pc,
   output logic            halt
);
   if (XLEN < 8) begin : g_chk_xlen
      $error("intc_timer_unit: XLEN too small");
   end
   if (HANDLER_ADDR[1:0] != 2'b00 || RESET_PC[1:0] != 2'b00) begin : g_chk_align
      $error("intc_timer_unit: addresses must be word aligned");
   end

   logic [NSRC-1:0] mask;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] clr;
   logic [IDXW-1:0] cause;
   logic            tmr_expire;
   logic            ill_trap;
   logic            take;
   logic            hit;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wdata;
   end

   intc_countdown #(.W(XLEN), .ENABLE(EN_TMR)) i_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_wdata),
      .expire(tmr_expire));

   assign ill_trap = ill_strobe && EN_ILL && mask[SRC_ILL] && !in_handler;

   intc_pending #(.EN_EXT(EN_EXT), .EN_TMR(EN_TMR), .EN_ILL(EN_ILL)) i_pend (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .tmr_expire(tmr_expire),
      .ill_set(ill_trap), .clr(clr), .pend(pend));

   assign hit   = |(pend & mask);
   assign cause = pick_src(pend & mask);
   assign clr   = take ? (NSRC'(1) << cause) : '0;
   assign req   = hit && !in_handler;

   intc_entry #(
      .XLEN(XLEN), .NSHD(4), .HANDLER_ADDR(HANDLER_ADDR), .RESET_PC(RESET_PC)
   ) i_entry (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .hit(hit),
      .cur_pc(cur_pc), .cause(cause), .ret_cmd(ret_cmd),
      .shd_we(shd_we), .shd_waddr(shd_waddr), .shd_wdata(shd_wdata),
      .shd_raddr(shd_raddr), .shd_rdata(shd_rdata),
      .active(in_handler), .take(take),
      .redirect(redirect), .redirect_pc(redirect_pc));

   always_ff @(posedge clk) begin
      if (!rst_n)                       halt <= 1'b0;
      else if (ill_strobe && !ill_trap) halt <= 1'b1;
   end

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   p_ill_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_strobe && !mask[SRC_ILL]) |=> halt);
   p_take_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));
endmodule

// File: tb/test_intc_timer_unit.sv
module test_intc_timer_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_req = 0, ill_strobe = 0, boundary = 0;
   logic [31:0] cur_pc = 0;
   logic        mask_we = 0;
   logic [4:0]  mask_wdata = 0;
   logic        tmr_load = 0;
   logic [31:0] tmr_wdata = 0;
   logic        ret_cmd = 0, shd_we = 0;
   logic [1:0]  shd_waddr = 0, shd_raddr = 0;
   logic [31:0] shd_wdata = 0;
   logic [31:0] shd_rdata, redirect_pc;
   logic        req, in_handler, redirect, halt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   intc_timer_unit i_intc_timer_unit (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ill_strobe(ill_strobe),
      .boundary(boundary), .cur_pc(cur_pc), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .tmr_load(tmr_load), .tmr_wdata(tmr_wdata),
      .ret_cmd(ret_cmd), .shd_we(shd_we), .shd_waddr(shd_waddr),
      .shd_wdata(shd_wdata), .shd_raddr(shd_raddr), .shd_rdata(shd_rdata),
      .req(req), .in_handler(in_handler), .redirect(redirect),
      .redirect_pc(redirect_pc), .halt(halt));

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; tick(); tick(); rst_n = 1; tick();
   endtask

   task automatic set_mask(input logic [4:0] m);
      mask_we = 1; mask_wdata = m; tick(); mask_we = 0;
   endtask

   task automatic pulse_ext();
      ext_req = 1; tick(); ext_req = 0;
   endtask

   // full entry: boundary with pc, then check save and cause steps
   task automatic do_entry(input logic [31:0] pc, input logic [31:0] num,
                           input string tag);
      boundary = 1; cur_pc = pc; tick(); boundary = 0;
      tick();
      chk(redirect && redirect_pc == 32'd16 && in_handler, {tag, " R5 redirect"},
          redirect_pc, 32'd16);
      shd_raddr = 0; #0.5;
      chk(shd_rdata == pc, {tag, " R5 saved pc"}, shd_rdata, pc);
      tick();
      chk(!redirect, {tag, " R11 pulse"}, 32'(redirect), 0);
      shd_raddr = 1; #0.5;
      chk(shd_rdata == num, {tag, " R6 cause"}, shd_rdata, num);
   endtask

   task automatic do_ret(input logic [31:0] pc, input string tag);
      ret_cmd = 1; tick(); ret_cmd = 0;
      chk(redirect && redirect_pc == pc && !in_handler, {tag, " R8 return"},
          redirect_pc, pc);
      tick();
   endtask

   task automatic t_reset();
      chk(!req && !in_handler && !halt && !redirect, "R1 reset outputs",
          {28'd0, req, in_handler, halt, redirect}, 0);
      repeat (40) tick();
      chk(!req && !redirect, "R1 no spontaneous request", 32'(req), 0);
   endtask

   task automatic t_shadow();
      shd_we = 1; shd_waddr = 2; shd_wdata = 32'hCAFE_0002; tick();
      shd_waddr = 3; shd_wdata = 32'hBEEF_0003; tick(); shd_we = 0;
      shd_raddr = 2; #0.5;
      chk(shd_rdata == 32'hCAFE_0002, "R10 shadow 2", shd_rdata, 32'hCAFE_0002);
      shd_raddr = 3; #0.5;
      chk(shd_rdata == 32'hBEEF_0003, "R10 shadow 3", shd_rdata, 32'hBEEF_0003);
   endtask

   task automatic t_ext_latch();
      pulse_ext(); tick();
      chk(!req, "R4 masked source gives no request", 32'(req), 0);
      boundary = 1; tick(); tick(); boundary = 0;
      chk(!redirect && !in_handler, "R4 no entry while masked", 32'(in_handler), 0);
      set_mask(5'b00001);
      chk(req, "R3 external bit held after line dropped", 32'(req), 1);
      do_entry(32'h100, 0, "ext");
      shd_raddr = 2; #0.5;
      chk(shd_rdata == 32'hCAFE_0002, "R5 shadow 2 untouched", shd_rdata, 32'hCAFE_0002);
      do_ret(32'h100, "ext");
      chk(!req, "R6 taken bit cleared", 32'(req), 0);
   endtask

   task automatic t_timer();
      set_mask(5'b00010);
      tmr_load = 1; tmr_wdata = 20; tick(); tmr_load = 0;
      repeat (19) tick();
      chk(!req, "R2 timer not yet expired at N-1", 32'(req), 0);
      tick();
      chk(req, "R2 timer expired after N cycles", 32'(req), 1);
      do_entry(32'h200, 1, "timer");
      do_ret(32'h200, "timer");
      tmr_load = 1; tmr_wdata = 0; tick(); tmr_load = 0;
      repeat (50) tick();
      chk(!req, "R2 zero load stays silent", 32'(req), 0);
   endtask

   task automatic t_priority();
      set_mask(5'b00011);
      ext_req = 1; tmr_load = 1; tmr_wdata = 1; tick();
      ext_req = 0; tmr_load = 0; tick();
      do_entry(32'h300, 0, "prio first");
      // R7: still active, both a pending timer and a new external request
      pulse_ext(); boundary = 1; tick(); tick(); tick(); boundary = 0;
      chk(!req && !redirect, "R7 no nested entry", 32'(redirect), 0);
      shd_raddr = 0; #0.5;
      chk(shd_rdata == 32'h300, "R7 saved pc kept", shd_rdata, 32'h300);
      do_ret(32'h300, "prio");
      chk(req, "R4 request after return", 32'(req), 1);
      do_entry(32'h304, 0, "prio second ext");
      do_ret(32'h304, "prio2");
      do_entry(32'h308, 1, "prio timer last");
      do_ret(32'h308, "prio3");
   endtask

   task automatic t_cause_none();
      set_mask(5'b00001);
      pulse_ext(); tick();
      boundary = 1; cur_pc = 32'h400; tick(); boundary = 0;
      mask_we = 1; mask_wdata = 0; tick(); mask_we = 0;
      tick();
      shd_raddr = 1; #0.5;
      chk(shd_rdata == 4, "R6 number 4 when nothing qualifies", shd_rdata, 4);
      do_ret(32'h400, "none");
      set_mask(5'b00001);
      chk(req, "R6 external bit not cleared by number 4", 32'(req), 1);
      do_entry(32'h404, 0, "none follow");
      do_ret(32'h404, "none2");
   endtask

   task automatic t_illegal();
      set_mask(5'b00100);
      ill_strobe = 1; tick(); ill_strobe = 0;
      chk(!halt && req, "R9 masked-in illegal traps", {30'd0, halt, req}, 1);
      do_entry(32'h500, 2, "ill");
      ill_strobe = 1; tick(); ill_strobe = 0;
      chk(halt, "R9 illegal inside handler halts", 32'(halt), 1);
      do_ret(32'h500, "ill");
      chk(halt, "R9 halt sticky", 32'(halt), 1);
      do_reset();
      ill_strobe = 1; tick(); ill_strobe = 0;
      chk(halt, "R9 illegal with mask bit 2 clear halts", 32'(halt), 1);
      repeat (5) tick();
      chk(halt, "R9 halt stays", 32'(halt), 1);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_shadow();
      t_ext_latch();
      t_timer();
      t_priority();
      t_cause_none();
      t_illegal();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule